// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block refills one cache line after a miss. It takes a miss request made of a line address and the offset of the word that missed. It then asks memory for a wrapped burst that starts at that word. Memory returns one word per beat, in a rotated order: first the missed word, then the words after it, and past the last word of the line back to word 0. Every beat is written through a line-fill write port. The first beat is also passed straight to the processor on a critical-word output, so the processor can resume while the rest of the line is still arriving.

While a fill is running, the controller keeps a per-word received mask. A processor read to the line being filled is answered from the words already collected. A read of a word that has not arrived yet is told to stall. When the last beat has been written, a one-cycle completion pulse carries the line address, so the tag can be set valid. Only one fill is in flight at a time. Tag lookup and the memory array are handled outside this block.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, fill_we, crit_valid, line_done, cpu_fwd_hit and cpu_fwd_stall are all 0.
- R2: From the cycle after a miss is accepted (miss_valid and miss_ready both high at a clock edge), mem_req_valid is high with mem_req_line equal to the missed line and mem_req_off equal to the missed word offset. Both values hold steady until mem_req_ready is sampled high.
- R3: miss_ready is 0 from the cycle after acceptance up to and including the cycle of the last beat. A miss_valid raised in that window is ignored: no new request is issued, and the line address reported at completion is still the first one.
- R4: During a fill, the k-th accepted beat (k counting from 0) drives fill_we high in the same cycle, with fill_idx = (missed offset + k) mod WORDS and fill_data equal to the beat data.
- R5: crit_valid is high for exactly one cycle per fill, in the cycle of the first beat, with crit_data equal to that beat's data. Its word index is the missed offset.
- R6: Any number of idle cycles (mem_beat_valid low) may fall between beats. fill_we is low in every idle cycle, and the beat order continues correctly afterwards.
- R7: line_done is a single-cycle pulse in the cycle after the WORDS-th beat, with done_line equal to the filled line. It is 0 in every earlier cycle of the fill. miss_ready returns to 1 in that same cycle.
- R8: While a fill is in flight, a cpu read (cpu_rd_valid) to the filling line of a word already written gives cpu_fwd_hit=1, cpu_fwd_stall=0 and cpu_fwd_data equal to that word.
- R9: While a fill is in flight, a cpu read to the filling line of a word not yet written gives cpu_fwd_stall=1 and cpu_fwd_hit=0. This includes the word arriving in that very cycle. When no fill is in flight, both flags are 0.
- R10: mem_beat_valid is ignored when no fill is in progress: fill_we and crit_valid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset that missed |
| miss_ready | output | 1 | Controller idle, can take a miss |
| mem_req_valid | output | 1 | Wrapped burst request to memory |
| mem_req_line | output | LINE_W | Line address of the burst |
| mem_req_off | output | OFF_W | Starting word of the burst |
| mem_req_ready | input | 1 | Memory took the request |
| mem_beat_valid | input | 1 | Memory data beat present |
| mem_beat_data | input | DATA_W | Memory beat data |
| fill_we | output | 1 | Line-fill write strobe |
| fill_idx | output | OFF_W | Word index written |
| fill_data | output | DATA_W | Word written |
| crit_valid | output | 1 | Critical word to processor |
| crit_data | output | DATA_W | Critical word data |
| line_done | output | 1 | Line complete, set tag valid |
| done_line | output | LINE_W | Line address that completed |
| cpu_rd_valid | input | 1 | Processor read probe |
| cpu_rd_line | input | LINE_W | Probe line address |
| cpu_rd_off | input | OFF_W | Probe word offset |
| cpu_fwd_hit | output | 1 | Probe served from fill data |
| cpu_fwd_stall | output | 1 | Probe word not yet received |
| cpu_fwd_data | output | DATA_W | Forwarded word |

## Verification
The hardest case to reach is a probe that lands on the word arriving in the same cycle, while other words of the line have already been collected. It must stall even though the data is on the bus. The stimulus reaches it by probing the word due on each beat, in the beat's own cycle. In the idle gaps it inserts between beats, it also probes the critical word, which has already arrived. Fills start at offset 0, at the last offset and in the middle, with gaps of none, one, two and five cycles. This makes the index wrap fall at a different beat in each fill, and one fill follows straight after another.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_FILL = 2'd2
    } fill_st_e;
endpackage

// File: rtl/cwf_seq.sv
module cwf_seq #(
    parameter int LINE_W = 24,
    parameter int WORDS  = 8,
    localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_off,
    output logic              miss_ready,
    output logic              miss_take,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [OFF_W-1:0]  mem_req_off,
    input  logic              mem_req_ready,
    input  logic              beat_valid,
    output logic              beat_take,
    output logic [OFF_W-1:0]  beat_idx,
    output logic              first_beat,
    output logic              active,
    output logic              line_done,
    output logic [LINE_W-1:0] done_line
);
    import cwf_pkg::*;

    localparam int SUM_W = OFF_W + 1;
    localparam logic [OFF_W-1:0] LAST_CNT = OFF_W'(WORDS - 1);

    typedef struct packed {
        fill_st_e          st;
        logic [LINE_W-1:0] line;
        logic [OFF_W-1:0]  off;
        logic [OFF_W-1:0]  cnt;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic [SUM_W-1:0] idx_sum;

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        miss_ready = (s_q.st == ST_IDLE);
        miss_take  = miss_valid && miss_ready;
        beat_take  = (s_q.st == ST_FILL) && beat_valid;
        first_beat = (s_q.cnt == '0);
        idx_sum    = SUM_W'(s_q.off) + SUM_W'(s_q.cnt);
        if (idx_sum >= SUM_W'(WORDS)) begin
            idx_sum = idx_sum - SUM_W'(WORDS);
        end
        beat_idx   = idx_sum[OFF_W-1:0];

        unique case (s_q.st)
            ST_IDLE: begin
                if (miss_take) begin
                    s_d.st   = ST_REQ;
                    s_d.line = miss_line;
                    s_d.off  = miss_off;
                    s_d.cnt  = '0;
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    s_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (beat_take) begin
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.st   = ST_IDLE;
                        s_d.cnt  = '0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, line: '0, off: '0, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_valid = (s_q.st == ST_REQ);
    assign mem_req_line  = s_q.line;
    assign mem_req_off   = s_q.off;
    assign active        = (s_q.st != ST_IDLE);
    assign line_done     = s_q.done;
    assign done_line     = s_q.line;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line)));

    // R3
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_take |-> !miss_ready);

    // R7
    done_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> $past(beat_take));
endmodule

// File: rtl/cwf_buf.sv
module cwf_buf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic              rd_got,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] word;
        logic [WORDS-1:0]             rcv;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clear) begin
            b_d.rcv = '0;
        end
        for (int i = 0; i < WORDS; i++) begin
            if (wr_en && (wr_idx == OFF_W'(i))) begin
                b_d.word[i] = wr_data;
                b_d.rcv[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_got  = b_q.rcv[rd_idx];
    assign rd_data = b_q.word[rd_idx];

    // R4
    write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> b_q.rcv[$past(wr_idx)]);
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
    parameter int LINE_W = 24,
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int OFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_off,
    output logic              miss_ready,
    output logic              mem_req_valid,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [OFF_W-1:0]  mem_req_off,
    input  logic              mem_req_ready,
    input  logic              mem_beat_valid,
    input  logic [DATA_W-1:0] mem_beat_data,
    output logic              fill_we,
    output logic [OFF_W-1:0]  fill_idx,
    output logic [DATA_W-1:0] fill_data,
    output logic              crit_valid,
    output logic [DATA_W-1:0] crit_data,
    output logic              line_done,
    output logic [LINE_W-1:0] done_line,
    input  logic              cpu_rd_valid,
    input  logic [LINE_W-1:0] cpu_rd_line,
    input  logic [OFF_W-1:0]  cpu_rd_off,
    output logic              cpu_fwd_hit,
    output logic              cpu_fwd_stall,
    output logic [DATA_W-1:0] cpu_fwd_data
);
    logic             miss_take;
    logic             beat_take;
    logic [OFF_W-1:0] beat_idx;
    logic             first_beat;
    logic             active;
    logic             rd_got;
    logic             probe_match;

    cwf_seq #(.LINE_W(LINE_W), .WORDS(WORDS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_line     (miss_line),
        .miss_off      (miss_off),
        .miss_ready    (miss_ready),
        .miss_take     (miss_take),
        .mem_req_valid (mem_req_valid),
        .mem_req_line  (mem_req_line),
        .mem_req_off   (mem_req_off),
        .mem_req_ready (mem_req_ready),
        .beat_valid    (mem_beat_valid),
        .beat_take     (beat_take),
        .beat_idx      (beat_idx),
        .first_beat    (first_beat),
        .active        (active),
        .line_done     (line_done),
        .done_line     (done_line)
    );

    cwf_buf #(.DATA_W(DATA_W), .WORDS(WORDS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (miss_take),
        .wr_en   (beat_take),
        .wr_idx  (beat_idx),
        .wr_data (mem_beat_data),
        .rd_idx  (cpu_rd_off),
        .rd_got  (rd_got),
        .rd_data (cpu_fwd_data)
    );

    always_comb begin
        fill_we       = beat_take;
        fill_idx      = beat_idx;
        fill_data     = mem_beat_data;
        crit_valid    = beat_take && first_beat;
        crit_data     = mem_beat_data;
        probe_match   = cpu_rd_valid && active && (cpu_rd_line == mem_req_line);
        cpu_fwd_hit   = probe_match && rd_got;
        cpu_fwd_stall = probe_match && !rd_got;
    end

    // R5
    crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid |-> (fill_we && (fill_idx == mem_req_off)));

    // R6
    no_beat_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_beat_valid |-> !fill_we);

    // R10
    idle_beat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ready && !line_done && !$past(mem_req_valid)) |-> !fill_we);
endmodule

// File: tb/sim_cwf_line_fill.sv
module sim_cwf_line_fill;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 24;
    localparam int DATA_W = 32;
    localparam int WORDS  = 8;
    localparam int OFF_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [LINE_W-1:0] miss_line = '0;
    logic [OFF_W-1:0]  miss_off = '0;
    logic              miss_ready;
    logic              mem_req_valid;
    logic [LINE_W-1:0] mem_req_line;
    logic [OFF_W-1:0]  mem_req_off;
    logic              mem_req_ready = 1'b0;
    logic              mem_beat_valid = 1'b0;
    logic [DATA_W-1:0] mem_beat_data = '0;
    logic              fill_we;
    logic [OFF_W-1:0]  fill_idx;
    logic [DATA_W-1:0] fill_data;
    logic              crit_valid;
    logic [DATA_W-1:0] crit_data;
    logic              line_done;
    logic [LINE_W-1:0] done_line;
    logic              cpu_rd_valid = 1'b0;
    logic [LINE_W-1:0] cpu_rd_line = '0;
    logic [OFF_W-1:0]  cpu_rd_off = '0;
    logic              cpu_fwd_hit;
    logic              cpu_fwd_stall;
    logic [DATA_W-1:0] cpu_fwd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwf_line_fill #(.LINE_W(LINE_W), .DATA_W(DATA_W), .WORDS(WORDS)) u0 (.*);

    function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] ln, input int idx);
        return {ln[23:0], 8'(8'hC0 + idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic t_reset();
        #1;
        chk(miss_ready == 1'b1, "R1 miss_ready", miss_ready, 1);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
        chk(fill_we == 1'b0, "R1 fill_we", fill_we, 0);
        chk(crit_valid == 1'b0, "R1 crit_valid", crit_valid, 0);
        chk(line_done == 1'b0, "R1 line_done", line_done, 0);
        chk(!cpu_fwd_hit && !cpu_fwd_stall, "R1 fwd flags", {cpu_fwd_hit, cpu_fwd_stall}, 0);
    endtask

    task automatic t_stray_beats();
        @(negedge clk);
        mem_beat_valid = 1'b1;
        mem_beat_data  = 32'hDEAD_BEEF;
        #1;
        chk(fill_we == 1'b0, "R10 fill_we idle", fill_we, 0);
        chk(crit_valid == 1'b0, "R10 crit_valid idle", crit_valid, 0);
        @(negedge clk);
        mem_beat_valid = 1'b0;
    endtask

    task automatic t_fill(input logic [LINE_W-1:0] ln, input int off, input int gap);
        int exp_idx;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = ln;
        miss_off   = OFF_W'(off);
        #1;
        chk(miss_ready == 1'b1, "R3 ready before accept", miss_ready, 1);
        @(negedge clk);
        miss_valid = 1'b0;
        #1;
        chk(mem_req_valid == 1'b1, "R2 req valid", mem_req_valid, 1);
        chk(mem_req_line == ln, "R2 req line", mem_req_line, ln);
        chk(int'(mem_req_off) == off, "R2 req off", mem_req_off, off);
        chk(miss_ready == 1'b0, "R3 ready low in request", miss_ready, 0);
        @(negedge clk);
        #1;
        chk(mem_req_valid == 1'b1 && int'(mem_req_off) == off, "R2 req held", mem_req_off, off);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        miss_valid    = 1'b1;
        miss_line     = ln ^ 24'h00F0F0;
        miss_off      = OFF_W'(off + 3);
        for (int k = 0; k < WORDS; k++) begin
            exp_idx = (off + k) % WORDS;
            if (k == WORDS - 1) miss_valid = 1'b0;
            for (int g = 0; g < gap; g++) begin
                mem_beat_valid = 1'b0;
                cpu_rd_valid   = 1'b1;
                cpu_rd_line    = ln;
                cpu_rd_off     = OFF_W'(off);
                #1;
                chk(fill_we == 1'b0, "R6 no write in gap", fill_we, 0);
                chk(miss_ready == 1'b0, "R3 ready low in fill", miss_ready, 0);
                chk(mem_req_valid == 1'b0, "R3 no second request", mem_req_valid, 0);
                if (k == 0) begin
                    chk(cpu_fwd_stall && !cpu_fwd_hit, "R9 stall before first beat", {cpu_fwd_hit, cpu_fwd_stall}, 1);
                end else begin
                    chk(cpu_fwd_hit && !cpu_fwd_stall, "R8 hit flags", {cpu_fwd_hit, cpu_fwd_stall}, 2);
                    chk(cpu_fwd_data == word_of(ln, off), "R8 hit data", cpu_fwd_data, word_of(ln, off));
                end
                @(negedge clk);
            end
            mem_beat_valid = 1'b1;
            mem_beat_data  = word_of(ln, exp_idx);
            cpu_rd_valid   = 1'b1;
            cpu_rd_line    = ln;
            cpu_rd_off     = OFF_W'(exp_idx);
            #1;
            chk(fill_we == 1'b1, "R4 fill_we", fill_we, 1);
            chk(int'(fill_idx) == exp_idx, "R4 fill_idx", fill_idx, exp_idx);
            chk(fill_data == word_of(ln, exp_idx), "R4 fill_data", fill_data, word_of(ln, exp_idx));
            chk(crit_valid == (k == 0), "R5 crit_valid", crit_valid, (k == 0));
            if (k == 0) begin
                chk(crit_data == word_of(ln, off), "R5 crit_data", crit_data, word_of(ln, off));
            end
            chk(cpu_fwd_stall && !cpu_fwd_hit, "R9 stall on arriving word", {cpu_fwd_hit, cpu_fwd_stall}, 1);
            chk(line_done == 1'b0, "R7 no early done", line_done, 0);
            @(negedge clk);
        end
        mem_beat_valid = 1'b0;
        cpu_rd_valid   = 1'b1;
        cpu_rd_line    = ln;
        cpu_rd_off     = OFF_W'(off);
        #1;
        chk(line_done == 1'b1, "R7 done pulse", line_done, 1);
        chk(done_line == ln, "R7 R3 done line", done_line, ln);
        chk(miss_ready == 1'b1, "R7 ready back", miss_ready, 1);
        chk(!cpu_fwd_hit && !cpu_fwd_stall, "R9 idle no forward", {cpu_fwd_hit, cpu_fwd_stall}, 0);
        @(negedge clk);
        cpu_rd_valid = 1'b0;
        #1;
        chk(line_done == 1'b0, "R7 single pulse", line_done, 0);
        chk(mem_req_valid == 1'b0, "R3 ignored miss not issued", mem_req_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        #(CLK_PERIOD * 2);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stray_beats();
        t_fill(24'h000123, 0, 0);
        t_fill(24'h00ABCD, 7, 2);
        t_fill(24'h0F0F0F, 3, 1);
        t_fill(24'h135790, 5, 5);
        t_stray_beats();
        finish_run();
    end
endmodule